// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reload Byte

This block is a supervision timer for a processor core. A free-running up-counter advances once for every machine-cycle enable while the watchdog is armed and the core is neither idle nor powered down. Arming is controlled by an 8-bit key: one fixed disarm code (55h) stops the timer, and any other value starts it. Every reset leaves the key at the disarm code, so the timer is off until firmware arms it.

Firmware services the timer by writing a reload byte. That write puts the byte into the top eight bits of the counter and clears all lower bits. Because the counter counts upward towards all-ones, a larger reload byte leaves fewer cycles before overflow, so the byte sets the timeout. When the counter steps from all-ones to zero, the block raises a reset request for one clock cycle and puts the disarm code back into the key by itself. The surrounding chip turns that request into a system reset.

Top module: `wdt_keyed`

## Requirements
- R1: With `rst_n` low at a clock edge, the key returns to 55h (disarmed), the counter returns to zero and `wdt_rst_req` is low after that edge. A reset in the middle of a countdown cancels it.
- R2: A key of 55h holds the counter at its present value. Any other key value lets it count. Writing the key (address 0) never changes the counter value.
- R3: While armed, the counter advances by exactly one in each cycle in which `mc_tick` is high.
- R4: The counter does not advance in a cycle where `idle_mode` or `pdown_mode` is high, or where `mc_tick` is low.
- R5: A write to the reload address (address 1) with byte d sets counter bits [CNT_W-1:CNT_W-8] to d and clears the lower bits, whether the timer is armed or not. With CNT_W bits the next overflow then comes after (2^CNT_W − d·2^(CNT_W−8)) advancing cycles, so a larger d gives a shorter timeout.
- R6: When an advancing cycle takes the counter from all-ones to zero, `wdt_rst_req` is high for exactly the one cycle after that clock edge and low in the cycle that follows.
- R7: The overflow edge loads the key with 55h, which disarms the timer. This also applies when a key write happens in the same cycle: the overflow wins.
- R8: If a reload write and an overflowing advance fall in the same cycle, the reload value is loaded and no reset request is produced.
- R9: Writes to addresses 2 and 3 have no effect on the key or on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle enable, one pulse per counted cycle |
| idle_mode | input | 1 | Core idle; freezes the counter |
| pdown_mode | input | 1 | Core powered down; freezes the counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Register address: 0 key, 1 reload, others unused |
| reg_wdata | input | 8 | Register write data |
| wdt_rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The assertions assume `rst_n` is held low for at least one clock edge before any write or tick matters. They also assume the write strobe, address and data are stable and free of X at each rising edge. The counter and key checks are made only outside reset. The bench changes every input on the falling edge and applies reset through a task that holds it low across whole cycles. It shortens the counter to 16 bits through the width parameter so that overflows are reached quickly, and a reference model computes the exact edge at which each reset request is expected.

// File: rtl/wdt_pkg.sv
// Package: shared types for the keyed watchdog.
// Assumes: nothing; only type and helper definitions live here.
package wdt_pkg;

    // Register selected by one bus write.
    typedef enum logic [1:0] {
        WSEL_NONE   = 2'd0,
        WSEL_KEY    = 2'd1,
        WSEL_RELOAD = 2'd2
    } wdt_sel_e;

    // Map an address to a register selection.
    function automatic wdt_sel_e addr_to_sel(input int unsigned addr,
                                             input int unsigned key_addr,
                                             input int unsigned rld_addr);
        if (addr == key_addr)
            return WSEL_KEY;
        else if (addr == rld_addr)
            return WSEL_RELOAD;
        else
            return WSEL_NONE;
    endfunction

endpackage

// File: rtl/wdt_regdec.sv
// Module: address decoder for the watchdog register bus.
// Turns one write strobe into separate key and reload strobes.
// Assumes: address and strobe are stable at the clock edge; unknown
// addresses produce no strobe.
module wdt_regdec
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int KEY_ADDR = 0,
    parameter int RLD_ADDR = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              key_wr,
    output logic              rld_wr
);

    wdt_sel_e sel;

    // Decode the address, then gate the result with the strobe.
    always_comb begin
        sel    = addr_to_sel(int'(wr_addr), KEY_ADDR, RLD_ADDR);
        key_wr = wr_en && (sel == WSEL_KEY);
        rld_wr = wr_en && (sel == WSEL_RELOAD);
    end

endmodule

// File: rtl/wdt_keyreg.sv
// Module: arming key register.
// Holds the key byte. The timer is armed whenever the key differs from
// the disarm code. Overflow forces the disarm code and beats a write
// in the same cycle.
// Assumes: synchronous active-low reset.
module wdt_keyreg #(
    parameter int          KEY_W      = 8,
    parameter logic [7:0]  DISARM_KEY = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             ovf,
    output logic [KEY_W-1:0] key_q,
    output logic             armed
);

    localparam logic [KEY_W-1:0] DIS = KEY_W'(DISARM_KEY);

    // Key register: reset and overflow load the disarm code, otherwise take writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= DIS;
        else if (ovf)
            key_q <= DIS;
        else if (key_wr)
            key_q <= wr_data;
    end

    // Arm flag follows the stored key.
    always_comb armed = (key_q != DIS);

    // After an overflow edge the timer must be disarmed (R7).
    assert_ovf_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !armed);

    // A key write with no overflow is stored exactly (R2).
    assert_key_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !ovf) |=> (key_q == $past(wr_data)));

endmodule

// File: rtl/wdt_counter.sv
// Module: watchdog up-counter with reload of the top byte.
// Counts on advance, loads {reload byte, zeros} on a reload write, and
// flags overflow when an advance leaves all-ones with no reload.
// Assumes: advance already includes arm, tick and low-power gating.
module wdt_counter #(
    parameter int CNT_W = 24,
    parameter int RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             rld_wr,
    input  logic [RLD_W-1:0] rld_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);

    localparam int LOW_W = CNT_W - RLD_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Overflow: an advance from all-ones that no reload overrides.
    always_comb ovf = advance && (&cnt_q) && !rld_wr;

    // Counter: reload has priority, then increment (wraps to zero).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rld_wr)
            cnt_q <= {rld_data, {LOW_W{1'b0}}};
        else if (advance)
            cnt_q <= cnt_q + ONE;
    end

    // A reload write places the byte on top and zeros below (R5).
    assert_reload_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rld_wr |=> (cnt_q[CNT_W-1:LOW_W] == $past(rld_data)) && (cnt_q[LOW_W-1:0] == '0));

    // An advance without reload moves the count by one (R3).
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !rld_wr) |=> (cnt_q == $past(cnt_q) + ONE));

    // With no advance and no reload the count stays put (R4).
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !rld_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_keyed.sv
// Module: keyed watchdog timer, top level.
// Combines decoder, key register and counter, gates the count with the
// machine-cycle enable and low-power modes, and registers the one-cycle
// reset request.
// Assumes: one clock domain; mc_tick, idle_mode and pdown_mode are
// synchronous to clk.
module wdt_keyed #(
    parameter int         CNT_W      = 24,
    parameter int         RLD_W      = 8,
    parameter int         ADDR_W     = 2,
    parameter int         KEY_ADDR   = 0,
    parameter int         RLD_ADDR   = 1,
    parameter logic [7:0] DISARM_KEY = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              idle_mode,
    input  logic              pdown_mode,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [RLD_W-1:0]  reg_wdata,
    output logic              wdt_rst_req
);

    logic             key_wr;
    logic             rld_wr;
    logic [RLD_W-1:0] key_q;
    logic             armed;
    logic             advance;
    logic             ovf;
    logic [CNT_W-1:0] cnt_q;

    wdt_regdec #(
        .ADDR_W  (ADDR_W),
        .KEY_ADDR(KEY_ADDR),
        .RLD_ADDR(RLD_ADDR)
    ) u_dec (
        .wr_en  (reg_wr),
        .wr_addr(reg_addr),
        .key_wr (key_wr),
        .rld_wr (rld_wr)
    );

    wdt_keyreg #(
        .KEY_W     (RLD_W),
        .DISARM_KEY(DISARM_KEY)
    ) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_wr (key_wr),
        .wr_data(reg_wdata),
        .ovf    (ovf),
        .key_q  (key_q),
        .armed  (armed)
    );

    // Count gate: armed, ticking, and not in a low-power mode.
    always_comb advance = armed && mc_tick && !idle_mode && !pdown_mode;

    wdt_counter #(
        .CNT_W(CNT_W),
        .RLD_W(RLD_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .rld_wr  (rld_wr),
        .rld_data(reg_wdata),
        .cnt_q   (cnt_q),
        .ovf     (ovf)
    );

    // Reset request register: high for the one cycle after an overflow edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdt_rst_req <= 1'b0;
        else
            wdt_rst_req <= ovf;
    end

    // The request never lasts two cycles (R6).
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    // While the request is high, the counter has just wrapped to zero (R6).
    assert_pulse_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> (cnt_q == '0));

    // While the request is high, the key already holds the disarm code (R7).
    assert_pulse_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> (key_q == DISARM_KEY) && !armed);

    // A reload write in a cycle blocks the request in the next one (R8).
    assert_reload_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rld_wr |=> !wdt_rst_req);

    // Low-power modes stop the count (R4).
    assert_lowpower_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((idle_mode || pdown_mode) && !rld_wr) |=> $stable(cnt_q));

endmodule

// File: tb/wdt_keyed_tb_top.sv
// Scoreboard bench for the keyed watchdog. A reference model in the
// driver predicts the clock edge of each reset request and queues it;
// a monitor samples after each edge and compares.
module wdt_keyed_tb_top;

    localparam int CW  = 16;
    localparam int RW  = 8;
    localparam int AW  = 2;
    localparam int MAX_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mc_tick = 1'b0;
    logic          idle_mode = 1'b0;
    logic          pdown_mode = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic          wdt_rst_req;

    int edge_cnt = 0;
    int total = 0;
    int bad = 0;
    int seen_pulses = 0;
    int exp_pulses = 0;
    int exp_q[$];

    // Reference model state
    logic [CW-1:0] m_cnt = '0;
    logic [RW-1:0] m_key = 8'h55;

    always #5 clk = ~clk;

    wdt_keyed #(
        .CNT_W(CW),
        .RLD_W(RW),
        .ADDR_W(AW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mc_tick    (mc_tick),
        .idle_mode  (idle_mode),
        .pdown_mode (pdown_mode),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .wdt_rst_req(wdt_rst_req)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: sample 2 ns after each rising edge and match against the queue.
    initial begin
        forever begin
            @(posedge clk);
            edge_cnt++;
            #2;
            while (exp_q.size() > 0 && exp_q[0] < edge_cnt) begin
                total++; bad++;
                $display("FAIL R6 missed request: actual=0 expected=1 at edge %0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0] == edge_cnt) begin
                void'(exp_q.pop_front());
                total++;
                if (wdt_rst_req !== 1'b1) begin
                    bad++;
                    $display("FAIL R6 request at edge %0d: actual=%b expected=1", edge_cnt, wdt_rst_req);
                end else begin
                    seen_pulses++;
                end
            end else if (wdt_rst_req !== 1'b0) begin
                total++; bad++;
                $display("FAIL R6 unexpected request at edge %0d: actual=%b expected=0", edge_cnt, wdt_rst_req);
            end
        end
    end

    // Watchdog for the bench itself.
    initial begin
        wait (edge_cnt >= MAX_CYC);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=<%0d", edge_cnt, MAX_CYC);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Driver: one cycle of stimulus, with model update and request prediction.
    task automatic drive(input logic tk, input logic idl, input logic pd,
                         input logic we, input logic [AW-1:0] ad, input logic [RW-1:0] d);
        logic adv, kw, rw, wrap;
        @(negedge clk);
        mc_tick = tk; idle_mode = idl; pdown_mode = pd;
        reg_wr = we; reg_addr = ad; reg_wdata = d;
        adv  = (m_key != 8'h55) && tk && !idl && !pd;
        kw   = we && (ad == 2'd0);
        rw   = we && (ad == 2'd1);
        wrap = adv && (&m_cnt) && !rw;
        if (wrap) begin
            exp_q.push_back(edge_cnt + 1);
            exp_pulses++;
        end
        if (rw)       m_cnt = {d, {(CW-RW){1'b0}}};
        else if (adv) m_cnt = m_cnt + 1'b1;
        if (wrap)     m_key = 8'h55;
        else if (kw)  m_key = d;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic wr(input logic [AW-1:0] ad, input logic [RW-1:0] d);
        drive(1'b0, 1'b0, 1'b0, 1'b1, ad, d);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        mc_tick = 1'b0; reg_wr = 1'b0;
        m_cnt = '0; m_key = 8'h55;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic phase_start;
        seen_pulses = 0;
        exp_pulses = 0;
    endtask

    task automatic phase_end(input string req, input string what, input int want);
        quiet(3);
        check_eq(req, {what, " model count"}, exp_pulses, want);
        check_eq(req, {what, " observed count"}, seen_pulses, want);
    endtask

    initial begin
        do_reset(3);
        #3;
        // R1: reset state, request low
        check_eq("R1", "request after reset", int'(wdt_rst_req), 0);

        // R2/R5: disarmed after reset; reload while disarmed, no counting
        phase_start();
        ticks(300);
        wr(2'd1, 8'hFF);
        ticks(300);
        phase_end("R2", "disarmed after reset", 0);

        // R3/R5/R6: arm; counter already at FF00 from the disarmed reload
        phase_start();
        wr(2'd0, 8'hA3);
        ticks(256);
        phase_end("R5", "reload FF timeout 256", 1);

        // R7: overflow disarmed the key; reload and run past a timeout
        phase_start();
        wr(2'd1, 8'hFF);
        ticks(400);
        phase_end("R7", "auto disarm after overflow", 0);

        // R5: larger byte is shorter: FE gives 512, 04 gives 64512
        phase_start();
        wr(2'd0, 8'h11);
        wr(2'd1, 8'hFE);
        ticks(512);
        phase_end("R5", "reload FE timeout 512", 1);
        phase_start();
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h04);
        ticks(64512);
        phase_end("R5", "reload 04 timeout 64512", 1);

        // R4: idle, power-down and missing tick freeze the count
        phase_start();
        wr(2'd0, 8'h2C);
        wr(2'd1, 8'hFF);
        ticks(100);
        for (int i = 0; i < 30; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        for (int i = 0; i < 30; i++) drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00);
        quiet(30);
        ticks(156);
        phase_end("R4", "freeze in idle and power-down", 1);

        // R2: key writes keep the count; a disarmed period holds it
        phase_start();
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFF);
        ticks(100);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h5A);
        ticks(20);
        wr(2'd0, 8'h55);
        ticks(50);
        wr(2'd0, 8'h01);
        ticks(135);
        phase_end("R2", "key writes leave counter", 1);

        // R3/R5: service restarts the timeout
        phase_start();
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hFF);
        ticks(200);
        wr(2'd1, 8'hFF);
        ticks(256);
        phase_end("R3", "service restarts countdown", 1);

        // R8: reload on the overflowing tick wins, then a full timeout follows
        phase_start();
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hFF);
        ticks(255);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'hFF);
        quiet(3);
        check_eq("R8", "no request on collision", seen_pulses, 0);
        ticks(256);
        phase_end("R8", "reload wins then timeout", 1);

        // R7: key write on the overflow edge loses to the disarm code
        phase_start();
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hFF);
        ticks(255);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h77);
        wr(2'd1, 8'hFF);
        ticks(300);
        phase_end("R7", "overflow beats key write", 1);

        // R9: unused addresses do not touch key or counter
        phase_start();
        wr(2'd0, 8'h42);
        wr(2'd1, 8'hFF);
        ticks(100);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h55);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 8'h00);
        ticks(154);
        phase_end("R9", "unused address ignored", 1);

        // R1: reset during a countdown cancels it
        phase_start();
        wr(2'd0, 8'h42);
        wr(2'd1, 8'hFF);
        ticks(200);
        do_reset(2);
        ticks(300);
        phase_end("R1", "reset cancels countdown", 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule